// File: doc/BRIEF.md
# Wavefront Cross-Lane Permute Unit

The unit reorders a 64-lane vector of 32-bit elements before it reaches a vector ALU. A 9-bit lane-control code tells each destination lane which source lane to read. The code space covers a full permute inside every group of four lanes, and shifts and rotates within a 16-lane row. It also covers shifts and rotates of the whole vector by one lane, a mirror of each row, and broadcasts that copy the last lane of a row into the rows above it.

The lanes form four rows of 16. Each lane also belongs to one of four banks, given by its index modulo 4. A row mask and a bank mask can disable lanes, and a disabled lane is never written. A source is unusable when it is out of bounds or when the execution mask marks it inactive. For such a source, the bound-control bit picks between writing zero and leaving the lane unwritten. Every source read comes from the input vector captured with the strobe, so no lane ever sees another lane's new value.

One cycle after each input strobe, the unit registers the result together with a per-lane write-enable. Lanes that are not written keep their previous registered value. A control code with no defined meaning raises an error flag, and then no lane is written.

Top module: `perm_xlane_unit`

## Requirements
- R1: While reset is asserted and after its release, out_valid, res_we and ctrl_err are 0 and every lane of res_vec is 0.
- R2: out_valid is 1 exactly one cycle after in_valid is 1. A cycle without in_valid gives out_valid=0, res_we=0 and ctrl_err=0 in the following cycle, and res_vec is unchanged.
- R3: For codes 0x000–0x0FF, destination lane k of a quad (k = lane mod 4) reads the lane of the same quad selected by code bits [2k+1:2k].
- R4: For codes 0x101–0x10F (n = code−0x100), row offset o reads offset o+n of the same row. For codes 0x111–0x11F (n = code−0x110), it reads offset o−n. Where the offset leaves the range 0–15, the source is out of bounds.
- R5: For codes 0x121–0x12F (n = code−0x120), row offset o reads offset (o−n+16) mod 16 of the same row, and the source is never out of bounds.
- R6: Code 0x130 makes lane i read lane i+1, and code 0x138 makes it read lane i−1. An index outside 0–63 is out of bounds.
- R7: Code 0x134 makes lane i read lane (i+1) mod 64, and code 0x13C makes it read lane (i−1) mod 64.
- R8: Code 0x140 makes row offset o read offset 15−o of the same row.
- R9: Code 0x142 gives every lane above 15 the value of lane (lane AND 0x30)−1. Code 0x143 gives lanes 32–63 the value of lane 31. Lower lanes are out of bounds under both codes.
- R10: A lane whose row_mask bit (lane/16) or bank_mask bit (lane mod 4) is 0 has res_we=0, and its res_vec lane is unchanged.
- R11: For an enabled lane whose source is out of bounds or inactive in exec_mask, bound_ctrl=1 gives res_we=1 with data 0. bound_ctrl=0 gives res_we=0, and the lane is unchanged.
- R12: Codes 0x100, 0x110, 0x120, 0x131–0x133, 0x135–0x137, 0x139–0x13B, 0x13D–0x13F, 0x141 and 0x144–0x1FF set ctrl_err=1 with res_we all 0, and res_vec is unchanged. Every other code gives ctrl_err=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input strobe |
| src_vec | input | 2048 | Source vector, lane i at bits [32i+31:32i] |
| lane_ctrl | input | 9 | Lane-control code |
| row_mask | input | 4 | Row enable, bit r covers lanes 16r–16r+15 |
| bank_mask | input | 4 | Bank enable, bit b covers lanes with index mod 4 = b |
| exec_mask | input | 64 | Per-lane source activity |
| bound_ctrl | input | 1 | 1: zero-fill unusable sources, 0: skip the lane |
| out_valid | output | 1 | Result registered from a strobe |
| res_vec | output | 2048 | Registered result vector |
| res_we | output | 64 | Per-lane write-enable of the last result |
| ctrl_err | output | 1 | Undefined control code seen |

## Verification
A wrong source index appears in the very next result as a lane holding a neighbour's value, whose lane and pattern tags reveal which index was taken. A fault in the boundary or mask logic appears in the same cycle as a wrong res_we bit, or as a zero where old data should have stayed. Because unwritten lanes keep their value, a write that should not have happened stays visible in res_vec, and later strobes carry it along until that lane is written again. Sweeping every code under several mask and bound-control settings exposes any decoder fault on the first strobe that carries the affected code.

// File: rtl/perm_pkg.sv
package perm_pkg;

   typedef enum logic [3:0] {
      OP_QUAD,
      OP_ROW_SHL,
      OP_ROW_SHR,
      OP_ROW_ROR,
      OP_WV_SHL,
      OP_WV_ROL,
      OP_WV_SHR,
      OP_WV_ROR,
      OP_MIRROR,
      OP_BC_ROW,
      OP_BC_HALF,
      OP_BAD
   } perm_op_e;

   typedef struct packed {
      perm_op_e   op;
      logic [3:0] amt;
      logic [7:0] quad_sel;
   } perm_cmd_t;

   localparam logic [8:0] CODE_WV_SHL  = 9'h130;
   localparam logic [8:0] CODE_WV_ROL  = 9'h134;
   localparam logic [8:0] CODE_WV_SHR  = 9'h138;
   localparam logic [8:0] CODE_WV_ROR  = 9'h13C;
   localparam logic [8:0] CODE_MIRROR  = 9'h140;
   localparam logic [8:0] CODE_BC_ROW  = 9'h142;
   localparam logic [8:0] CODE_BC_HALF = 9'h143;

endpackage

// File: rtl/perm_decode.sv
module perm_decode
   import perm_pkg::*;
(
   input  logic [8:0] code,
   output perm_cmd_t  cmd
);

   always_comb begin
      cmd.op       = OP_BAD;
      cmd.amt      = code[3:0];
      cmd.quad_sel = code[7:0];
      if (!code[8]) begin
         cmd.op = OP_QUAD;
      end else if (code[7:4] == 4'h0) begin
         if (code[3:0] != 4'h0) cmd.op = OP_ROW_SHL;
      end else if (code[7:4] == 4'h1) begin
         if (code[3:0] != 4'h0) cmd.op = OP_ROW_SHR;
      end else if (code[7:4] == 4'h2) begin
         if (code[3:0] != 4'h0) cmd.op = OP_ROW_ROR;
      end else begin
         case (code)
            CODE_WV_SHL:  cmd.op = OP_WV_SHL;
            CODE_WV_ROL:  cmd.op = OP_WV_ROL;
            CODE_WV_SHR:  cmd.op = OP_WV_SHR;
            CODE_WV_ROR:  cmd.op = OP_WV_ROR;
            CODE_MIRROR:  cmd.op = OP_MIRROR;
            CODE_BC_ROW:  cmd.op = OP_BC_ROW;
            CODE_BC_HALF: cmd.op = OP_BC_HALF;
            default:      cmd.op = OP_BAD;
         endcase
      end
   end

endmodule

// File: rtl/perm_lane_src.sv
module perm_lane_src
   import perm_pkg::*;
#(
   parameter int LANES     = 64,
   parameter int ROW_LANES = 16,
   parameter int LANE      = 0,
   localparam int LW       = $clog2(LANES)
) (
   input  perm_cmd_t     cmd,
   output logic [LW-1:0] src_idx,
   output logic          oob
);

   localparam int ROW  = LANE / ROW_LANES;
   localparam int OFF  = LANE % ROW_LANES;
   localparam int BASE = ROW * ROW_LANES;
   localparam int QK   = LANE % 4;
   localparam int QB   = LANE - QK;
   localparam int HALF = 2 * ROW_LANES;

   int t;

   always_comb begin
      t   = LANE;
      oob = 1'b0;
      case (cmd.op)
         OP_QUAD: t = QB + int'(cmd.quad_sel[2*QK +: 2]);
         OP_ROW_SHL: begin
            t = OFF + int'(cmd.amt);
            if (t >= ROW_LANES) oob = 1'b1;
            t = BASE + t;
         end
         OP_ROW_SHR: begin
            t = OFF - int'(cmd.amt);
            if (t < 0) oob = 1'b1;
            t = BASE + t;
         end
         OP_ROW_ROR: t = BASE + ((OFF - int'(cmd.amt) + ROW_LANES) % ROW_LANES);
         OP_WV_SHL: begin
            t = LANE + 1;
            if (t >= LANES) oob = 1'b1;
         end
         OP_WV_ROL: t = (LANE + 1) % LANES;
         OP_WV_SHR: begin
            t = LANE - 1;
            if (t < 0) oob = 1'b1;
         end
         OP_WV_ROR: t = (LANE + LANES - 1) % LANES;
         OP_MIRROR: t = BASE + (ROW_LANES - 1 - OFF);
         OP_BC_ROW: begin
            if (LANE >= ROW_LANES) t = BASE - 1;
            else oob = 1'b1;
         end
         OP_BC_HALF: begin
            if (LANE >= HALF) t = (LANE / HALF) * HALF - 1;
            else oob = 1'b1;
         end
         default: t = LANE;
      endcase
      src_idx = t[LW-1:0];
   end

endmodule

// File: rtl/perm_lane_sel.sv
module perm_lane_sel #(
   parameter int LANES = 64,
   parameter int DW    = 32,
   localparam int LW   = $clog2(LANES)
) (
   input  logic [LANES*DW-1:0] src_flat,
   input  logic [LANES-1:0]    exec_mask,
   input  logic [LW-1:0]       src_idx,
   input  logic                oob,
   input  logic                lane_en,
   input  logic                bound_ctrl,
   input  logic                bad,
   output logic                wr,
   output logic [DW-1:0]       wdata
);

   logic [DW-1:0] picked;
   logic          src_live;

   assign picked   = src_flat[src_idx*DW +: DW];
   assign src_live = !oob && exec_mask[src_idx];

   always_comb begin
      wr    = 1'b0;
      wdata = '0;
      if (!bad && lane_en) begin
         if (src_live) begin
            wr    = 1'b1;
            wdata = picked;
         end else if (bound_ctrl) begin
            wr    = 1'b1;
         end
      end
   end

endmodule

// File: rtl/perm_xlane_unit.sv
module perm_xlane_unit
   import perm_pkg::*;
#(
   parameter int LANES     = 64,
   parameter int ROW_LANES = 16,
   parameter int DW        = 32,
   localparam int ROWS     = LANES / ROW_LANES,
   localparam int BANKS    = 4,
   localparam int LW       = $clog2(LANES)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_valid,
   input  logic [LANES*DW-1:0] src_vec,
   input  logic [8:0]          lane_ctrl,
   input  logic [ROWS-1:0]     row_mask,
   input  logic [BANKS-1:0]    bank_mask,
   input  logic [LANES-1:0]    exec_mask,
   input  logic                bound_ctrl,
   output logic                out_valid,
   output logic [LANES*DW-1:0] res_vec,
   output logic [LANES-1:0]    res_we,
   output logic                ctrl_err
);

   if (ROW_LANES != 16) begin : g_bad_row
      $error("perm_xlane_unit: ROW_LANES must be 16");
   end
   if ((LANES < 64) || (LANES % (2 * ROW_LANES) != 0)) begin : g_bad_lanes
      $error("perm_xlane_unit: LANES must be a multiple of 32, at least 64");
   end
   if (DW < 1) begin : g_bad_dw
      $error("perm_xlane_unit: DW must be positive");
   end

   perm_cmd_t            cmd;
   logic                 bad;
   logic [LANES-1:0]     lane_en_vec;
   logic [LANES-1:0]     wr_vec;
   logic [LANES*DW-1:0]  wdata_vec;

   perm_decode u_dec (
      .code (lane_ctrl),
      .cmd  (cmd)
   );

   assign bad = (cmd.op == OP_BAD);

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic [LW-1:0] sidx;
      logic          soob;

      assign lane_en_vec[i] = row_mask[i / ROW_LANES] & bank_mask[i % BANKS];

      perm_lane_src #(
         .LANES     (LANES),
         .ROW_LANES (ROW_LANES),
         .LANE      (i)
      ) u_src (
         .cmd     (cmd),
         .src_idx (sidx),
         .oob     (soob)
      );

      perm_lane_sel #(
         .LANES (LANES),
         .DW    (DW)
      ) u_sel (
         .src_flat   (src_vec),
         .exec_mask  (exec_mask),
         .src_idx    (sidx),
         .oob        (soob),
         .lane_en    (lane_en_vec[i]),
         .bound_ctrl (bound_ctrl),
         .bad        (bad),
         .wr         (wr_vec[i]),
         .wdata      (wdata_vec[i*DW +: DW])
      );

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            res_vec[i*DW +: DW] <= '0;
         end else if (in_valid && wr_vec[i]) begin
            res_vec[i*DW +: DW] <= wdata_vec[i*DW +: DW];
         end
      end

      // R10 R11
      hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !res_we[i] |-> $stable(res_vec[i*DW +: DW]));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         res_we    <= '0;
         ctrl_err  <= 1'b0;
      end else begin
         out_valid <= in_valid;
         res_we    <= in_valid ? wr_vec : '0;
         ctrl_err  <= in_valid & bad;
      end
   end

   // R2
   valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   // R2
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && res_we == '0 && !ctrl_err));

   // R12
   err_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_err |-> (res_we == '0));

   // R10
   mask_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> ((res_we & ~$past(lane_en_vec)) == '0));

   // R11
   zero_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && bound_ctrl && !bad) |=> ((res_we | ~$past(lane_en_vec)) == '1));

endmodule

// File: tb/sim_perm_xlane_unit.sv
`timescale 1ns/1ps
module sim_perm_xlane_unit;

   localparam int LANES = 64;
   localparam int DW    = 32;

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic                in_valid = 1'b0;
   logic [LANES*DW-1:0] src_vec = '0;
   logic [8:0]          lane_ctrl = '0;
   logic [3:0]          row_mask = '0;
   logic [3:0]          bank_mask = '0;
   logic [LANES-1:0]    exec_mask = '0;
   logic                bound_ctrl = 1'b0;
   logic                out_valid;
   logic [LANES*DW-1:0] res_vec;
   logic [LANES-1:0]    res_we;
   logic                ctrl_err;

   int n_chk = 0;
   int n_bad = 0;
   logic [DW-1:0]    exp_res [LANES];
   logic [LANES-1:0] exp_we;
   logic             exp_err;
   logic [31:0]      lfsr = 32'h1ACE_B00C;

   always #2 clk = ~clk;

   perm_xlane_unit u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_valid   (in_valid),
      .src_vec    (src_vec),
      .lane_ctrl  (lane_ctrl),
      .row_mask   (row_mask),
      .bank_mask  (bank_mask),
      .exec_mask  (exec_mask),
      .bound_ctrl (bound_ctrl),
      .out_valid  (out_valid),
      .res_vec    (res_vec),
      .res_we     (res_we),
      .ctrl_err   (ctrl_err)
   );

   function automatic logic [31:0] rnd();
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      return lfsr;
   endfunction

   // -1 out of bounds, -2 undefined code
   function automatic int ref_src(int code, int l);
      int o = l % 16;
      int n;
      if (code < 256) return (l & ~3) + ((code >> (2 * (l % 4))) & 3);       // R3
      if (code >= 'h101 && code <= 'h10F) begin                               // R4
         n = code - 'h100;
         return (o + n < 16) ? l + n : -1;
      end
      if (code >= 'h111 && code <= 'h11F) begin                               // R4
         n = code - 'h110;
         return (o - n >= 0) ? l - n : -1;
      end
      if (code >= 'h121 && code <= 'h12F) begin                               // R5
         n = code - 'h120;
         return (l / 16) * 16 + ((o - n + 16) % 16);
      end
      if (code == 'h130) return (l + 1 < 64) ? l + 1 : -1;                   // R6
      if (code == 'h138) return (l > 0) ? l - 1 : -1;                        // R6
      if (code == 'h134) return (l + 1) % 64;                                // R7
      if (code == 'h13C) return (l + 63) % 64;                               // R7
      if (code == 'h140) return (l / 16) * 16 + 15 - o;                      // R8
      if (code == 'h142) return (l > 15) ? (l & 'h30) - 1 : -1;              // R9
      if (code == 'h143) return (l > 31) ? 31 : -1;                          // R9
      return -2;                                                              // R12
   endfunction

   function automatic string tag_of(int code);
      if (code < 256) return "R3";
      if (code <= 'h11F) return "R4";
      if (code <= 'h12F) return "R5";
      if (code == 'h130 || code == 'h138) return "R6";
      if (code == 'h134 || code == 'h13C) return "R7";
      if (code == 'h140) return "R8";
      return "R9";
   endfunction

   task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic check_out(string req, logic exp_valid);
      check("R2", "out_valid", 64'(out_valid), 64'(exp_valid));
      check("R12", "ctrl_err", 64'(ctrl_err), 64'(exp_err));
      for (int l = 0; l < LANES; l++) begin
         check(req, $sformatf("we lane %0d", l), 64'(res_we[l]), 64'(exp_we[l]));
         check(req, $sformatf("data lane %0d", l), 64'(res_vec[l*DW +: DW]), 64'(exp_res[l]));
      end
   endtask

   task automatic run_one(int code, int pat);
      string req;
      int    s;
      logic  en;
      logic [DW-1:0] sv [LANES];
      string lreq [LANES];
      for (int l = 0; l < LANES; l++) begin
         sv[l] = {16'(pat * 7 + code), 8'(l), ~8'(l)};
         src_vec[l*DW +: DW] = sv[l];
      end
      lane_ctrl = 9'(code);
      in_valid  = 1'b1;
      exp_err   = 1'b0;
      for (int l = 0; l < LANES; l++) begin
         en = row_mask[l / 16] & bank_mask[l % 4];
         s  = ref_src(code, l);
         exp_we[l] = 1'b0;
         lreq[l] = tag_of(code);
         if (s == -2) begin
            exp_err = 1'b1;
            lreq[l] = "R12";
         end else if (!en) begin
            lreq[l] = "R10";
         end else if (s >= 0 && exec_mask[s]) begin
            exp_we[l]  = 1'b1;
            exp_res[l] = sv[s];
         end else begin
            lreq[l] = "R11";
            if (bound_ctrl) begin
               exp_we[l]  = 1'b1;
               exp_res[l] = '0;
            end
         end
      end
      @(negedge clk);
      check("R2", "out_valid", 64'(out_valid), 64'd1);
      check("R12", "ctrl_err", 64'(ctrl_err), 64'(exp_err));
      for (int l = 0; l < LANES; l++) begin
         req = lreq[l];
         check(req, $sformatf("code %h we lane %0d", code, l), 64'(res_we[l]), 64'(exp_we[l]));
         check(req, $sformatf("code %h data lane %0d", code, l),
               64'(res_vec[l*DW +: DW]), 64'(exp_res[l]));
      end
   endtask

   task automatic run_idle();
      in_valid = 1'b0;
      src_vec  = {LANES{32'hDEAD_BEEF}};
      exp_we   = '0;
      exp_err  = 1'b0;
      @(negedge clk);
      check_out("R2", 1'b0);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=expired expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin : main
      for (int l = 0; l < LANES; l++) exp_res[l] = '0;
      exp_we  = '0;
      exp_err = 1'b0;
      repeat (3) @(negedge clk);
      check_out("R1", 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      check_out("R1", 1'b0);
      for (int p = 0; p < 4; p++) begin
         for (int code = 0; code < 512; code++) begin
            row_mask   = (p >= 2) ? rnd()[3:0] : 4'hF;
            bank_mask  = (p >= 2) ? rnd()[7:4] : 4'hF;
            exec_mask  = (p == 0) ? '1 : {rnd(), rnd()};
            bound_ctrl = (p == 1) ? 1'b1 : (p == 3) ? rnd()[9] : 1'b0;
            run_one(code, p);
            if (code % 37 == 0) run_idle();
         end
      end
      run_idle();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule